// File: doc/BRIEF.md
# Register-Mapped Packet FIFO with Event Interrupt

This block is a 32-bit word FIFO that a processor fills and drains through two small memory-mapped windows. The data window holds the word register and a sideband register. The sideband marks packet start and end, gives the count of unused bytes in a short final word, and carries a channel number and an error code. A writer first stores the sideband. The next word write then pushes the word and that sideband into the queue as one entry. A reader pops a word by reading the word register. A sideband read right after the pop returns the tags that travelled with that word. In a short final word the valid bytes sit at the most significant end.

The control window reports the fill level and a live status vector. It holds sticky events, a per-event interrupt mask, and two programmable thresholds, one for almost-full and one for almost-empty. A single interrupt line is high while any event is pending and its mask bit is set. Writers are expected to poll the fill level and to hold off while it equals the depth. A write to a full queue is still caught: it is dropped and flagged. A read of an empty queue is caught the same way.

Top module: `pkt_fifo_regs`

## Requirements
- R1: A write to data-window offset 0x04 latches a sideband. Bit 0 is start, bit 1 is end, bits 6:2 are the empty-byte count, bits 15:8 are the channel and bits 23:16 are the error code. Bit 7 and bits 31:24 are discarded. The next write to offset 0x00 stores the word together with the latched sideband. Every write to 0x00 then returns the latch to zero.
- R2: A read of data-window offset 0x00 returns the oldest stored word and removes it. A later read of offset 0x04 returns the sideband of the word most recently removed, in the R1 layout, with the discarded bits reading 0. Words leave in the order they were accepted.
- R3: A word write while the fill level equals DEPTH (default 16) is dropped. The fill level stays unchanged and the overflow event (bit 4) is set.
- R4: A word read while the queue is empty returns 0 and sets the underflow event (bit 5). A following sideband read returns 0.
- R5: Control offset 0x00 reads the number of stored words.
- R6: Control offset 0x04 reads the live status. Bit 0 is full (level equals DEPTH). Bit 1 is empty (level 0). Bit 2 is almost-full (level at least the 0x10 threshold). Bit 3 is almost-empty (level at most the 0x14 threshold). Bit 4 is high from a dropped write until the next accepted write. Bit 5 is high from an empty read until the next successful read.
- R7: Control offset 0x08 reads the events in the same bit order. Bits 3:0 are set one cycle after the matching status bit rises from 0 to 1. Bits 4 and 5 are set by the offending access. Events stay set until a write to 0x08 with a 1 in that position clears them.
- R8: The interrupt output is high exactly when some event bit and the same bit of the mask at control offset 0x0C (bits 5:0) are both 1.
- R9: The thresholds at control offsets 0x10 and 0x14 can be written and read back.
- R10: After reset the queue is empty and status reads 0x0A. Events and mask are 0. The thresholds are DEPTH-1 and 1, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d_wr | input | 1 | Data window write strobe |
| d_rd | input | 1 | Data window read strobe |
| d_addr | input | 3 | Data window byte offset |
| d_wdata | input | 32 | Data window write value |
| d_rdata | output | 32 | Data window read value, valid in the cycle of d_rd |
| c_wr | input | 1 | Control window write strobe |
| c_rd | input | 1 | Control window read strobe |
| c_addr | input | 5 | Control window byte offset |
| c_wdata | input | 32 | Control window write value |
| c_rdata | output | 32 | Control window read value, valid in the cycle of c_rd |
| irq | output | 1 | Interrupt, high while an enabled event is pending |

## Verification
A pointer or level that drifts shows up as a wrong word or wrong sideband on the very next pop. It also shows up in the fill level, which is read directly. A mistaken rise detector or a lost sticky bit shows in the event register one access later. Because the interrupt pin is compared on every access of the random run, a wrong event or mask bit shows at the pin in the access where it goes wrong, not at the end of the run.

// File: rtl/pktfifo_pkg.sv
package pktfifo_pkg;

    // Per-word sideband carried alongside each stored data word
    typedef struct packed {
        logic [7:0] err;
        logic [7:0] chan;
        logic [4:0] nempty;
        logic       eop;
        logic       sop;
    } side_t;

    typedef struct packed {
        logic [31:0] data;
        side_t       side;
    } entry_t;

    // Flag bit positions shared by status, event and mask
    localparam int NFLAG  = 6;
    localparam int F_FULL = 0;
    localparam int F_EMP  = 1;
    localparam int F_AF   = 2;
    localparam int F_AE   = 3;
    localparam int F_OVF  = 4;
    localparam int F_UDF  = 5;

    // Data window offsets
    localparam logic [2:0] DW_WORD = 3'h0;
    localparam logic [2:0] DW_SIDE = 3'h4;

    // Control window offsets
    localparam logic [4:0] CW_LEVEL = 5'h00;
    localparam logic [4:0] CW_STAT  = 5'h04;
    localparam logic [4:0] CW_EVT   = 5'h08;
    localparam logic [4:0] CW_MASK  = 5'h0C;
    localparam logic [4:0] CW_AFTH  = 5'h10;
    localparam logic [4:0] CW_AETH  = 5'h14;

    function automatic side_t side_from_word(input logic [31:0] w);
        side_t s;
        s.err    = w[23:16];
        s.chan   = w[15:8];
        s.nempty = w[6:2];
        s.eop    = w[1];
        s.sop    = w[0];
        return s;
    endfunction

    function automatic logic [31:0] side_to_word(input side_t s);
        return {8'h00, s.err, s.chan, 1'b0, s.nempty, s.eop, s.sop};
    endfunction

endpackage

// File: rtl/pf_store.sv
module pf_store
    import pktfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  entry_t           wr_entry,
    output entry_t           head,
    output logic [CNT_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             push_ok,
    output logic             pop_ok
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    entry_t           mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    assign full    = (level == CNT_W'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (level == $past(level))); // R3
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R6
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((level == $past(level)) || (level == $past(level) + 1'b1)
                  || (level + 1'b1 == $past(level)))); // R5
endmodule

// File: rtl/pf_flags.sv
module pf_flags
    import pktfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] level,
    input  logic             full,
    input  logic             empty,
    input  logic [CNT_W-1:0] af_thr,
    input  logic [CNT_W-1:0] ae_thr,
    input  logic             push_bad,
    input  logic             push_ok,
    input  logic             pop_bad,
    input  logic             pop_ok,
    input  logic [NFLAG-1:0] clr,
    output logic [NFLAG-1:0] live,
    output logic [NFLAG-1:0] evt
);
    logic       ovf_st, udf_st;
    logic [3:0] lvl_prev;
    logic [NFLAG-1:0] set_v;

    always_comb begin
        live         = '0;
        live[F_FULL] = full;
        live[F_EMP]  = empty;
        live[F_AF]   = (level >= af_thr);
        live[F_AE]   = (level <= ae_thr);
        live[F_OVF]  = ovf_st;
        live[F_UDF]  = udf_st;
    end

    always_comb begin
        set_v        = '0;
        set_v[3:0]   = live[3:0] & ~lvl_prev;
        set_v[F_OVF] = push_bad;
        set_v[F_UDF] = pop_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_st   <= 1'b0;
            udf_st   <= 1'b0;
            lvl_prev <= 4'b1010;   // empty and almost-empty hold out of reset
            evt      <= '0;
        end else begin
            if (push_bad)     ovf_st <= 1'b1;
            else if (push_ok) ovf_st <= 1'b0;
            if (pop_bad)      udf_st <= 1'b1;
            else if (pop_ok)  udf_st <= 1'b0;
            lvl_prev <= live[3:0];
            evt      <= (evt & ~clr) | set_v;
        end
    end

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((($past(evt) & ~$past(clr))) & ~evt) == '0)); // R7
    AST_OVF_EVENT: assert property (@(posedge clk) disable iff (rst)
        push_bad |=> evt[F_OVF]); // R3
    AST_UDF_EVENT: assert property (@(posedge clk) disable iff (rst)
        pop_bad |=> evt[F_UDF]); // R4
endmodule

// File: rtl/pkt_fifo_regs.sv
module pkt_fifo_regs
    import pktfifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        d_wr,
    input  logic        d_rd,
    input  logic [2:0]  d_addr,
    input  logic [31:0] d_wdata,
    output logic [31:0] d_rdata,
    input  logic        c_wr,
    input  logic        c_rd,
    input  logic [4:0]  c_addr,
    input  logic [31:0] c_wdata,
    output logic [31:0] c_rdata,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    side_t            side_latch, side_popped;
    entry_t           head;
    logic [CNT_W-1:0] level, af_thr, ae_thr;
    logic             full, empty, push, pop, push_ok, pop_ok;
    logic [NFLAG-1:0] live, evt, mask, clr;
    logic             unused_bits;

    assign push = d_wr && (d_addr == DW_WORD);
    assign pop  = d_rd && (d_addr == DW_WORD);
    assign clr  = (c_wr && c_addr == CW_EVT) ? c_wdata[NFLAG-1:0] : '0;
    assign unused_bits = ^{c_wdata[31:CNT_W], d_wdata[31:24], d_wdata[7]};

    pf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .wr_entry('{data: d_wdata, side: side_latch}),
        .head(head), .level(level), .full(full), .empty(empty),
        .push_ok(push_ok), .pop_ok(pop_ok)
    );

    pf_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
        .clk(clk), .rst(rst), .level(level), .full(full), .empty(empty),
        .af_thr(af_thr), .ae_thr(ae_thr),
        .push_bad(push && !push_ok), .push_ok(push_ok),
        .pop_bad(pop && !pop_ok), .pop_ok(pop_ok),
        .clr(clr), .live(live), .evt(evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            side_latch  <= '0;
            side_popped <= '0;
        end else begin
            if (d_wr && d_addr == DW_SIDE) side_latch <= side_from_word(d_wdata);
            else if (push)                 side_latch <= '0;
            if (pop_ok)   side_popped <= head.side;
            else if (pop) side_popped <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask   <= '0;
            af_thr <= CNT_W'(DEPTH - 1);
            ae_thr <= CNT_W'(1);
        end else if (c_wr) begin
            if (c_addr == CW_MASK) mask   <= c_wdata[NFLAG-1:0];
            if (c_addr == CW_AFTH) af_thr <= c_wdata[CNT_W-1:0];
            if (c_addr == CW_AETH) ae_thr <= c_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        d_rdata = '0;
        if (d_rd) begin
            if (d_addr == DW_WORD && !empty) d_rdata = head.data;
            else if (d_addr == DW_SIDE)      d_rdata = side_to_word(side_popped);
        end
    end

    always_comb begin
        c_rdata = '0;
        if (c_rd) begin
            case (c_addr)
                CW_LEVEL: c_rdata = 32'(level);
                CW_STAT:  c_rdata = 32'(live);
                CW_EVT:   c_rdata = 32'(evt);
                CW_MASK:  c_rdata = 32'(mask);
                CW_AFTH:  c_rdata = 32'(af_thr);
                CW_AETH:  c_rdata = 32'(ae_thr);
                default:  c_rdata = '0;
            endcase
        end
    end

    assign irq = |(evt & mask);

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |-> (d_rdata == '0)); // R4
    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        irq |-> (evt != '0)); // R8
    AST_LATCH_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        push |=> (side_latch == '0)); // R1
endmodule

// File: tb/sim_pkt_fifo_regs.sv
`timescale 1ns/1ps
module sim_pkt_fifo_regs;
    localparam int DEPTH = 16;
    localparam logic [31:0] SIDE_KEEP = 32'h00FF_FF7F;

    logic        clk = 1'b0, rst = 1'b1;
    logic        d_wr = 0, d_rd = 0, c_wr = 0, c_rd = 0;
    logic [2:0]  d_addr = '0;
    logic [4:0]  c_addr = '0;
    logic [31:0] d_wdata = '0, c_wdata = '0;
    logic [31:0] d_rdata, c_rdata;
    logic        irq;

    int checks = 0, errors = 0;

    // reference model state
    logic [63:0] q[$];
    logic [31:0] m_latch = 0, m_popped = 0;
    logic [5:0]  m_ev = 0, m_ie = 0;
    logic [31:0] m_af = DEPTH - 1, m_ae = 1;
    logic        m_ovs = 0, m_uds = 0;
    logic [3:0]  m_prev = 4'b1010;

    always #2.5 clk = ~clk;

    pkt_fifo_regs #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .d_wr(d_wr), .d_rd(d_rd), .d_addr(d_addr),
        .d_wdata(d_wdata), .d_rdata(d_rdata), .c_wr(c_wr), .c_rd(c_rd),
        .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata), .irq(irq)
    );

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] m_live();
        int n = q.size();
        return {m_uds, m_ovs, 1'(n <= int'(m_ae)), 1'(n >= int'(m_af)),
                1'(n == 0), 1'(n == DEPTH)};
    endfunction

    function automatic logic [31:0] ctrl_exp(input logic [4:0] a);
        case (a)
            5'h00: return 32'(q.size());
            5'h04: return 32'(m_live());
            5'h08: return 32'(m_ev);
            5'h0C: return 32'(m_ie);
            5'h10: return m_af;
            5'h14: return m_ae;
            default: return 32'h0;
        endcase
    endfunction

    // rise detection the cycle after an access
    task automatic settle();
        logic [5:0] l = m_live();
        m_ev[3:0] |= l[3:0] & ~m_prev;
        m_prev = l[3:0];
    endtask

    // one access: drive at negedge, sample before posedge, then one idle cycle
    task automatic bus(input bit ctl, input bit wr, input logic [4:0] a,
                       input logic [31:0] w, output logic [31:0] r);
        logic exp_irq = |(m_ev & m_ie);
        if (ctl) begin c_wr = wr; c_rd = !wr; c_addr = a; c_wdata = w; end
        else begin d_wr = wr; d_rd = !wr; d_addr = a[2:0]; d_wdata = w; end
        #2;
        r = ctl ? c_rdata : d_rdata;
        chk("R8 irq pin", 32'(irq), 32'(exp_irq));
        @(negedge clk);
        c_wr = 0; c_rd = 0; d_wr = 0; d_rd = 0;
        @(negedge clk);
    endtask

    task automatic op_side_wr(input logic [31:0] w);
        logic [31:0] r;
        bus(0, 1, 5'h04, w, r);
        m_latch = w & SIDE_KEEP;
        settle();
    endtask

    task automatic op_push(input logic [31:0] w);
        logic [31:0] r;
        bus(0, 1, 5'h00, w, r);
        if (q.size() == DEPTH) begin
            m_ovs = 1; m_ev[4] = 1;
        end else begin
            q.push_back({w, m_latch}); m_ovs = 0;
        end
        m_latch = 0;
        settle();
    endtask

    task automatic op_pop(input string req);
        logic [31:0] r, e;
        e = (q.size() == 0) ? 32'h0 : q[0][63:32];
        bus(0, 0, 5'h00, 0, r);
        chk(req, r, e);
        if (q.size() == 0) begin
            m_uds = 1; m_ev[5] = 1; m_popped = 0;
        end else begin
            m_popped = q[0][31:0]; void'(q.pop_front()); m_uds = 0;
        end
        settle();
    endtask

    task automatic op_side_rd(input string req);
        logic [31:0] r;
        bus(0, 0, 5'h04, 0, r);
        chk(req, r, m_popped);
        settle();
    endtask

    task automatic op_crd(input logic [4:0] a, input string req);
        logic [31:0] r, e;
        e = ctrl_exp(a);
        bus(1, 0, a, 0, r);
        chk(req, r, e);
        settle();
    endtask

    task automatic op_cwr(input logic [4:0] a, input logic [31:0] w);
        logic [31:0] r;
        bus(1, 1, a, w, r);
        case (a)
            5'h08: m_ev &= ~w[5:0];
            5'h0C: m_ie = w[5:0];
            5'h10: m_af = 32'(w[4:0]);
            5'h14: m_ae = 32'(w[4:0]);
            default: ;
        endcase
        settle();
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R10 reset state
        chk("R10 irq after reset", 32'(irq), 0);
        op_crd(5'h00, "R10 level after reset");
        op_crd(5'h04, "R10 status after reset");
        chk("R10 status literal", ctrl_exp(5'h04), 32'h0A);
        op_crd(5'h08, "R10 events after reset");
        op_crd(5'h0C, "R10 mask after reset");
        op_crd(5'h10, "R9 R10 af threshold default");
        op_crd(5'h14, "R9 R10 ae threshold default");

        // R1 R2 packet with sideband, reserved bits discarded
        op_side_wr(32'h0000_0501);
        op_push(32'hA1A2_A3A4);
        op_push(32'hB1B2_B3B4);
        op_side_wr(32'hFF12_0086);
        op_push(32'hC1C2_0000);
        op_crd(5'h00, "R5 level after three pushes");
        op_pop("R2 first word");
        op_side_rd("R2 start sideband");
        op_pop("R2 second word");
        op_side_rd("R1 latch consumed by prior push");
        op_pop("R2 last word");
        op_side_rd("R1 end sideband reserved cleared");

        // R3 R6 fill to full and overflow
        for (int i = 0; i < DEPTH; i++) op_push(32'h1000_0000 + 32'(i));
        op_crd(5'h04, "R6 status when full");
        op_crd(5'h08, "R7 events after filling");
        op_push(32'hDEAD_BEEF);
        op_crd(5'h00, "R3 level unchanged on overflow");
        op_crd(5'h08, "R3 overflow event");
        op_crd(5'h04, "R6 overflow status held");
        op_cwr(5'h0C, 32'h10);
        op_crd(5'h0C, "R8 mask readback");
        op_cwr(5'h08, 32'h10);
        op_crd(5'h08, "R7 write one clears");

        // R4 drain and underflow
        for (int i = 0; i < DEPTH; i++) op_pop("R2 drain order");
        op_pop("R4 empty read returns zero");
        op_side_rd("R4 sideband zero after underflow");
        op_crd(5'h08, "R4 underflow event");
        op_cwr(5'h0C, 32'h20);
        op_crd(5'h04, "R6 underflow status");
        op_cwr(5'h10, 32'd3);
        op_cwr(5'h14, 32'd0);
        op_crd(5'h10, "R9 af threshold write");
        op_crd(5'h14, "R9 ae threshold write");
        op_cwr(5'h08, 32'h3F);

        // constrained random mix
        for (int k = 0; k < 1500; k++) begin
            int sel = int'($urandom_range(0, 11));
            case (sel)
                0, 1, 2: begin
                    if ($urandom_range(0, 1) == 1) op_side_wr($urandom);
                    op_push($urandom);
                end
                3, 4:  op_pop("R2 random pop");
                5:     op_side_rd("R2 random sideband");
                6:     op_crd(5'h04, "R6 random status");
                7:     op_crd(5'h08, "R7 random events");
                8:     op_crd(5'h00, "R5 random level");
                9:     op_cwr(5'h08, 32'($urandom_range(0, 63)));
                10:    op_cwr(5'h0C, 32'($urandom_range(0, 63)));
                default: op_cwr($urandom_range(0, 1) == 1 ? 5'h10 : 5'h14,
                                32'($urandom_range(0, DEPTH)));
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule